// File: doc/BRIEF.md
# Receive-Level XON/XOFF Injector

This block keeps a far-end transmitter from overrunning the local receive FIFO. It watches the FIFO's fill count and the host's read strobe. When the count climbs to a programmed halt threshold, it asks the local transmitter for a priority slot and hands over a pause code (XOFF). When host reads bring the count back down to a programmed resume threshold, it hands over a go code (XON). The block remembers which kind of code it sent last. This gives hysteresis: one XOFF per halt episode, and XON only after an XOFF.

Codes are offered with a request/take handshake. The transmitter takes the offered character at its next character boundary, ahead of any user data. In dual mode each event sends an ordered pair of codes, and the two characters of a pair go out back to back. If the fill level crosses back before the first character of a pending event has been taken, the request is withdrawn. A pair that has already started is always finished.

Top module: `rxfc_gen`

## Requirements
- R1: While enabled and not in a halt episode, a fill count greater than or equal to the halt threshold opens a halt episode at the next clock edge. From that cycle on, `inj_req` is high with `inj_char` equal to the first pause code. A count one below the threshold does nothing; a threshold of 128 triggers at a count of 128.
- R2: Once the pause code (or pair) of an episode has been taken, no further request is raised while the count stays at or above the halt threshold.
- R3: During a halt episode, the episode ends when two things are true: at least one `fifo_rd` pulse has been seen in the episode (a pulse in the current cycle counts), and the count is at or below the resume threshold. From the next cycle, a request with the first go code is raised. Without a read, a low count ends nothing.
- R4: A go code is never sent unless a pause code was sent before it. A low fill count from reset raises no request.
- R5: With `cfg_dual`=1, a pair is offered in a fixed order. The pause pair is offered as `cfg_xoff1` then `cfg_xoff2`, and the go pair as `cfg_xon1` then `cfg_xon2`. The second code is offered in the cycle right after the first is taken.
- R6: `inj_req` stays high and `inj_char` stays unchanged until `tx_take` is sampled high at a clock edge. Each high sample takes exactly one character.
- R7: If the episode state flips back to match the last completed event before the first character has been taken, the request is withdrawn from the next cycle and no character is sent. This applies both to a pending pause code and to a pending go code.
- R8: Once the first code of a pair has been taken, the second follows even if the level crosses back. The opposite pair is then requested directly after it.
- R9: With `cfg_enable`=0, `inj_req` is low and all episode and sent state returns to "running". Enabling again at a low count raises no request.
- R10: While `rst` is high, `inj_req` is low. After release the block is in the running state.
- R11: With `cfg_dual`=0, each event sends only its first code (`cfg_xoff1` or `cfg_xon1`), and no second character is offered after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables automatic receive flow control |
| cfg_dual | input | 1 | 1: two-character codes, 0: one character |
| cfg_halt_lvl | input | 8 | Fill count that opens a halt episode (0..128) |
| cfg_resume_lvl | input | 8 | Fill count that ends a halt episode (0..128) |
| cfg_xoff1 | input | 8 | First pause code |
| cfg_xoff2 | input | 8 | Second pause code (dual mode) |
| cfg_xon1 | input | 8 | First go code |
| cfg_xon2 | input | 8 | Second go code (dual mode) |
| fifo_count | input | 8 | Receive FIFO fill count |
| fifo_rd | input | 1 | Host read strobe of the receive FIFO |
| tx_take | input | 1 | Transmitter takes the offered character at this edge |
| inj_req | output | 1 | A flow-control character is offered |
| inj_char | output | 8 | Character offered for injection |

## Verification
Two functions can fall in the same cycle. The first is the transmitter taking the first character of a pair. The second is the fill level crossing the opposite threshold. The stimulus table provokes this by pulsing a read with a count below the resume level while the second pause code is still pending. It then expects the whole sequence: the second pause code, then the go pair, with no truncation and no duplicate. A second case pairs a threshold crossing with a request that has not yet been taken. This is judged by the request dropping with no character handed over, for both a pending pause code and a pending go code.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] fc_char_t;

    typedef enum logic {
        FK_RUN  = 1'b0,
        FK_HALT = 1'b1
    } flow_kind_e;

    typedef struct packed {
        fc_char_t xoff1;
        fc_char_t xoff2;
        fc_char_t xon1;
        fc_char_t xon2;
    } flow_codes_t;

    function automatic fc_char_t pick_code(flow_codes_t codes, flow_kind_e kind, logic second);
        fc_char_t c;
        if (kind == FK_HALT) c = second ? codes.xoff2 : codes.xoff1;
        else                 c = second ? codes.xon2  : codes.xon1;
        return c;
    endfunction

endpackage

// File: rtl/rxfc_level_mon.sv
module rxfc_level_mon
    import rxfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] fill,
    input  logic             rd,
    input  logic [CNT_W-1:0] halt_lvl,
    input  logic [CNT_W-1:0] resume_lvl,
    output flow_kind_e       target
);

    logic       read_seen;
    flow_kind_e target_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            target_q  <= FK_RUN;
            read_seen <= 1'b0;
        end else if (target_q == FK_RUN) begin
            read_seen <= 1'b0;
            if (fill >= halt_lvl) target_q <= FK_HALT;
        end else begin
            if ((read_seen || rd) && (fill <= resume_lvl)) begin
                target_q  <= FK_RUN;
                read_seen <= 1'b0;
            end else if (rd) begin
                read_seen <= 1'b1;
            end
        end
    end

    assign target = target_q;

endmodule

// File: rtl/rxfc_inject_seq.sv
module rxfc_inject_seq
    import rxfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        dual,
    input  flow_kind_e  target,
    input  flow_codes_t codes,
    input  logic        take,
    output logic        req,
    output fc_char_t    char_out,
    output logic        mid_pair,
    output logic        sent_halt
);

    flow_kind_e sent_q;
    flow_kind_e mid_kind;
    logic       mid_q;
    logic       handoff;

    assign req     = enable && (mid_q || (target != sent_q));
    assign handoff = req && take;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            sent_q   <= FK_RUN;
            mid_q    <= 1'b0;
            mid_kind <= FK_RUN;
        end else if (handoff) begin
            if (mid_q) begin
                mid_q  <= 1'b0;
                sent_q <= mid_kind;
            end else if (dual) begin
                mid_q    <= 1'b1;
                mid_kind <= target;
            end else begin
                sent_q <= target;
            end
        end
    end

    assign char_out  = mid_q ? pick_code(codes, mid_kind, 1'b1)
                             : pick_code(codes, target, 1'b0);
    assign mid_pair  = mid_q;
    assign sent_halt = (sent_q == FK_HALT);

endmodule

// File: rtl/rxfc_gen.sv
module rxfc_gen
    import rxfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_dual,
    input  logic [CNT_W-1:0] cfg_halt_lvl,
    input  logic [CNT_W-1:0] cfg_resume_lvl,
    input  logic [7:0]       cfg_xoff1,
    input  logic [7:0]       cfg_xoff2,
    input  logic [7:0]       cfg_xon1,
    input  logic [7:0]       cfg_xon2,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_rd,
    input  logic             tx_take,
    output logic             inj_req,
    output logic [7:0]       inj_char
);

    flow_kind_e  target;
    flow_codes_t codes;
    logic        target_halt;
    logic        mid_pair;
    logic        sent_halt;

    assign codes = '{xoff1: cfg_xoff1, xoff2: cfg_xoff2, xon1: cfg_xon1, xon2: cfg_xon2};
    assign target_halt = (target == FK_HALT);

    rxfc_level_mon #(.CNT_W(CNT_W)) u_mon (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg_enable),
        .fill       (fifo_count),
        .rd         (fifo_rd),
        .halt_lvl   (cfg_halt_lvl),
        .resume_lvl (cfg_resume_lvl),
        .target     (target)
    );

    rxfc_inject_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .dual      (cfg_dual),
        .target    (target),
        .codes     (codes),
        .take      (tx_take),
        .req       (inj_req),
        .char_out  (inj_char),
        .mid_pair  (mid_pair),
        .sent_halt (sent_halt)
    );

endmodule

// File: rtl/rxfc_gen_chk.sv
module rxfc_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_dual,
    input logic [CNT_W-1:0] cfg_halt_lvl,
    input logic [CNT_W-1:0] fifo_count,
    input logic             tx_take,
    input logic             inj_req,
    input logic [7:0]       inj_char,
    input logic             target_halt,
    input logic             mid_pair,
    input logic             sent_halt
);

    p_halt_entry_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_enable && !target_halt && (fifo_count >= cfg_halt_lvl) |=> target_halt);

    p_one_xoff_r2: assert property (@(posedge clk) disable iff (rst)
        sent_halt && target_halt && !mid_pair |-> !inj_req);

    p_hold_offer_r6: assert property (@(posedge clk) disable iff (rst)
        inj_req && !tx_take && mid_pair && cfg_enable
        |=> !cfg_enable || (inj_req && $stable(inj_char)));

    p_pair_opens_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_enable && cfg_dual && inj_req && tx_take && !mid_pair |=> mid_pair);

    p_off_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !mid_pair && !sent_halt && !target_halt);

    p_single_no_pair_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_dual && !mid_pair |=> !mid_pair);

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !mid_pair && !sent_halt);

endmodule

bind rxfc_gen rxfc_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_enable   (cfg_enable),
    .cfg_dual     (cfg_dual),
    .cfg_halt_lvl (cfg_halt_lvl),
    .fifo_count   (fifo_count),
    .tx_take      (tx_take),
    .inj_req      (inj_req),
    .inj_char     (inj_char),
    .target_halt  (target_halt),
    .mid_pair     (mid_pair),
    .sent_halt    (sent_halt)
);

// File: tb/rxfc_gen_tb_top.sv
`timescale 1ns/1ps
module rxfc_gen_tb_top;

    localparam logic [7:0] XOFF1 = 8'h13;
    localparam logic [7:0] XOFF2 = 8'h93;
    localparam logic [7:0] XON1  = 8'h11;
    localparam logic [7:0] XON2  = 8'h91;
    localparam int NVEC = 24;

    // {count, rd, take, expected req, expected char}
    localparam logic [18:0] VEC [NVEC] = '{
        {8'd10,  1'b0, 1'b0, 1'b0, 8'h00},  // R4 low level, no go code
        {8'd100, 1'b0, 1'b0, 1'b0, 8'h00},  // R1 reaches halt
        {8'd100, 1'b0, 1'b0, 1'b1, XOFF1},  // R1 first pause code, R6 held
        {8'd101, 1'b0, 1'b1, 1'b1, XOFF1},  // R6 taken
        {8'd101, 1'b0, 1'b0, 1'b1, XOFF2},  // R5 second follows
        {8'd101, 1'b0, 1'b1, 1'b1, XOFF2},
        {8'd102, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 no repeat
        {8'd60,  1'b1, 1'b0, 1'b0, 8'h00},
        {8'd40,  1'b1, 1'b0, 1'b0, 8'h00},  // R3 reaches resume
        {8'd39,  1'b0, 1'b0, 1'b1, XON1},
        {8'd39,  1'b0, 1'b1, 1'b1, XON1},   // R5 go pair order
        {8'd39,  1'b0, 1'b1, 1'b1, XON2},
        {8'd39,  1'b0, 1'b0, 1'b0, 8'h00},
        {8'd120, 1'b0, 1'b0, 1'b0, 8'h00},
        {8'd120, 1'b1, 1'b0, 1'b1, XOFF1},
        {8'd30,  1'b1, 1'b0, 1'b1, XOFF1},  // R7 crosses back untaken
        {8'd30,  1'b0, 1'b0, 1'b0, 8'h00},  // R7 withdrawn
        {8'd110, 1'b0, 1'b0, 1'b0, 8'h00},
        {8'd110, 1'b0, 1'b1, 1'b1, XOFF1},
        {8'd20,  1'b1, 1'b0, 1'b1, XOFF2},  // R8 crossing mid pair
        {8'd20,  1'b0, 1'b1, 1'b1, XOFF2},
        {8'd20,  1'b0, 1'b1, 1'b1, XON1},   // R8 opposite pair right after
        {8'd20,  1'b0, 1'b1, 1'b1, XON2},
        {8'd20,  1'b0, 1'b0, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_enable, cfg_dual;
    logic [7:0] cfg_halt_lvl, cfg_resume_lvl;
    logic [7:0] fifo_count;
    logic       fifo_rd, tx_take;
    logic       inj_req;
    logic [7:0] inj_char;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rxfc_gen dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_enable     (cfg_enable),
        .cfg_dual       (cfg_dual),
        .cfg_halt_lvl   (cfg_halt_lvl),
        .cfg_resume_lvl (cfg_resume_lvl),
        .cfg_xoff1      (XOFF1),
        .cfg_xoff2      (XOFF2),
        .cfg_xon1       (XON1),
        .cfg_xon2       (XON2),
        .fifo_count     (fifo_count),
        .fifo_rd        (fifo_rd),
        .tx_take        (tx_take),
        .inj_req        (inj_req),
        .inj_char       (inj_char)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive inputs away from the edge; outputs then show pre-edge state
    task automatic drive(logic [7:0] cnt, logic rd, logic take);
        @(negedge clk);
        fifo_count = cnt;
        fifo_rd    = rd;
        tx_take    = take;
        #1;
    endtask

    task automatic expect_out(string tag, logic req, logic [7:0] ch);
        check(tag, {7'd0, inj_req}, {7'd0, req});
        if (req) check(tag, inj_char, ch);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        fifo_count = 8'd0; fifo_rd = 1'b0; tx_take = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cfg_enable = 1'b1; cfg_dual = 1'b1;
        cfg_halt_lvl = 8'd100; cfg_resume_lvl = 8'd40;
        fifo_count = 8'd120; fifo_rd = 1'b0; tx_take = 1'b0;

        // R10: reset keeps request low even at a high level
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset req", {7'd0, inj_req}, 8'd0);
        do_reset();

        // table walk, dual mode
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][18:11], VEC[i][10], VEC[i][9]);
            expect_out($sformatf("R1-R8 table row %0d", i), VEC[i][8], VEC[i][7:0]);
        end

        // R1: threshold at full depth, R3: read needed, R7: go code withdrawn
        do_reset();
        cfg_halt_lvl = 8'd128;
        drive(8'd127, 0, 0); expect_out("R1 below max", 1'b0, 8'h00);
        drive(8'd127, 0, 0); expect_out("R1 below max", 1'b0, 8'h00);
        drive(8'd128, 0, 0); expect_out("R1 at max", 1'b0, 8'h00);
        drive(8'd128, 0, 1); expect_out("R1 at max", 1'b1, XOFF1);
        drive(8'd128, 0, 1); expect_out("R5 second", 1'b1, XOFF2);
        drive(8'd30, 0, 0);  expect_out("R2 idle", 1'b0, 8'h00);
        drive(8'd30, 0, 0);  expect_out("R3 no read", 1'b0, 8'h00);
        drive(8'd30, 1, 0);  expect_out("R3 no read", 1'b0, 8'h00);
        drive(8'd128, 0, 0); expect_out("R3 go", 1'b1, XON1);
        drive(8'd128, 0, 0); expect_out("R7 go withdrawn", 1'b0, 8'h00);

        // R11: single mode; R9: disable clears state
        do_reset();
        cfg_halt_lvl = 8'd100; cfg_dual = 1'b0;
        drive(8'd100, 0, 0); expect_out("R11 idle", 1'b0, 8'h00);
        drive(8'd100, 0, 1); expect_out("R11 pause", 1'b1, XOFF1);
        drive(8'd100, 0, 0); expect_out("R11 no second", 1'b0, 8'h00);
        drive(8'd30, 1, 0);  expect_out("R11 idle", 1'b0, 8'h00);
        drive(8'd30, 0, 1);  expect_out("R11 go", 1'b1, XON1);
        drive(8'd30, 0, 0);  expect_out("R11 no second", 1'b0, 8'h00);
        drive(8'd100, 0, 0); expect_out("R9 setup", 1'b0, 8'h00);
        drive(8'd100, 0, 1); expect_out("R9 setup", 1'b1, XOFF1);
        cfg_enable = 1'b0;
        drive(8'd100, 0, 0); expect_out("R9 disabled", 1'b0, 8'h00);
        drive(8'd30, 0, 0);  expect_out("R9 disabled", 1'b0, 8'h00);
        cfg_enable = 1'b1;
        drive(8'd30, 0, 0);  expect_out("R9 re-enabled", 1'b0, 8'h00);
        drive(8'd30, 0, 0);  expect_out("R9 re-enabled", 1'b0, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule